// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of every line of one cache attached to a shared snooping bus. It uses four states: invalid, shared, exclusive-clean and modified. A small direct-mapped array holds a tag and a state per index. The processor side accepts one read or write at a time and holds it until it completes. A read of a valid line completes at once. So does a write to an exclusive or modified line. Any other access raises a bus request carrying a read, read-for-ownership or upgrade command. The access completes in the cycle the grant arrives. On a read fill, the wired-OR shared line sampled during the grant cycle chooses between the shared and exclusive states.

The snoop side sees the transactions of other caches, one per cycle. For each one it returns three things in the same cycle: the shared-line drive, a mandatory dirty flush, and an optional clean cache-to-cache flush. It then updates the line state at the next rising edge. When several caches hold clean copies, the clean flush comes only from the holder with the lowest cache number.

The bus arbiter never grants this cache in a cycle that carries a snoop. The processor keeps its address and direction stable until completion.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads as invalid (state code 0) and no bus request is raised. State codes are: invalid 0, shared 1, exclusive 2, modified 3.
- R2: A read of an absent line requests a read (command code 1). In the grant cycle it fills the line as exclusive (2) when `bus_shared` is low and as shared (1) when it is high.
- R3: A read of a shared, exclusive or modified line, and a write to an exclusive or modified line, complete in the same cycle with no bus request. After such a write the line is modified.
- R4: A write to an absent line requests read-for-ownership (code 2). A write to a shared line requests an upgrade (code 3), or read-for-ownership when `USE_UPGRADE` is 0. Both end in the modified state. A pending upgrade whose line is invalidated by a snoop turns into read-for-ownership.
- R5: A request holds `bus_req` with `pr_ready` low and leaves the line state unchanged until `bus_gnt`. `pr_ready` is high in the grant cycle and the new state is visible after that rising edge.
- R6: A snooped read on a modified line drives `snp_flush` and leaves the line shared. A snooped read-for-ownership on a modified line drives `snp_flush` and leaves it invalid.
- R7: A snooped read on an exclusive or shared line leaves it shared. A snooped read-for-ownership or upgrade (code 3) on such a line leaves it invalid, and an upgrade moves no data.
- R8: `snp_flush_c2c` is high only when `C2C_EN` is set, the line is shared or exclusive, the command is read or read-for-ownership, and bit `MY_ID` is the lowest set bit of `snp_holders`.
- R9: `snp_shared_drv` is high for a snooped read whenever this cache holds the line in any valid state.
- R10: A snoop to an index whose stored tag differs, or whose line is invalid, drives no response and changes no state.
- R11: `pr_src` reports the source of the data when `pr_ready` is high: own cache 0 for a valid line, memory 1 for a fill without sharing or for read-for-ownership, peer cache 2 for a read fill with `bus_shared` high and `C2C_EN` set.
- R12: When a snoop updates the same index as a local hit in the same cycle, the snoop is applied and the local access is withheld (`pr_ready` low) and re-evaluated in the next cycle.
- R13: A processor access whose tag differs from the stored tag counts as a miss, and its fill replaces the stored tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pr_valid | input | 1 | Processor access pending |
| pr_write | input | 1 | 1 = write, 0 = read |
| pr_addr | input | TAG_W+IDX_W | Line address, index in the low bits |
| pr_ready | output | 1 | Access completes this cycle |
| pr_hit | output | 1 | Addressed line is valid |
| pr_state | output | 2 | State of the addressed line (I when the tag differs) |
| pr_src | output | 2 | Data source of the completing access |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Requested command: 1 read, 2 read-for-ownership, 3 upgrade |
| bus_addr | output | TAG_W+IDX_W | Address of the requested transaction |
| bus_gnt | input | 1 | Bus granted; the transaction happens this cycle |
| bus_shared | input | 1 | Wired-OR shared line, sampled during the grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | TAG_W+IDX_W | Snooped line address |
| snp_holders | input | NCACHE | One bit per cache that holds a valid copy |
| snp_shared_drv | output | 1 | Drive onto the wired-OR shared line |
| snp_flush | output | 1 | Mandatory flush of dirty data |
| snp_flush_c2c | output | 1 | Optional clean cache-to-cache supply |

## Verification
Hit completions, bus requests and all three snoop responses are combinational on the inputs of the current cycle. The bench therefore drives each stimulus just after a rising edge and checks these outputs at the following falling edge. A miss completes in the cycle its grant is driven, so the bench checks `pr_ready` and `pr_src` at the falling edge of that same cycle. Before the grant it checks once per stall cycle that the request holds and the state has not moved. Every state change becomes visible one rising edge later. The bench reads it back through `pr_state` at the next falling edge, and for snoops it addresses the resident tag so that unchanged lines can be seen too.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPG  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        SRC_OWN  = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_PEER = 2'd2
    } data_src_e;

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    output logic [1:0]       rd_a_st,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [TAG_W-1:0] rd_b_tag,
    output logic [1:0]       rd_b_st,
    input  logic             pw_en,
    input  logic [IDX_W-1:0] pw_idx,
    input  logic [TAG_W-1:0] pw_tag,
    input  logic [1:0]       pw_st,
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [1:0]       sw_st
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][1:0]       st;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pw_en) begin
            s_d.tag[pw_idx] = pw_tag;
            s_d.st[pw_idx]  = pw_st;
        end
        if (sw_en) begin
            s_d.st[sw_idx] = sw_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_a_tag = s_q.tag[rd_a_idx];
    assign rd_a_st  = s_q.st[rd_a_idx];
    assign rd_b_tag = s_q.tag[rd_b_idx];
    assign rd_b_st  = s_q.st[rd_b_idx];

    // R12: the two write ports never target one index in the same cycle
    assert_port_clash_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pw_en && sw_en && (pw_idx == sw_idx)));

endmodule

// File: rtl/mesi_lowest_pick.sv
module mesi_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_pick
        assign pick[i]   = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int    TAG_W  = 4,
    parameter int    NCACHE = 4,
    parameter int    MY_ID  = 1,
    parameter bit    C2C_EN = 1'b1
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [NCACHE-1:0] holders,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [1:0]        line_st,
    output logic              we,
    output logic [1:0]        new_st,
    output logic              shared_drv,
    output logic              flush,
    output logic              flush_c2c
);
    logic [NCACHE-1:0] pick;
    line_st_e          st;
    bus_cmd_e          cmd;
    logic              present;
    logic              clean;
    logic              data_cmd;

    mesi_lowest_pick #(.N(NCACHE)) u_pick (
        .req  (holders),
        .pick (pick)
    );

    always_comb begin
        st       = line_st_e'(line_st);
        cmd      = bus_cmd_e'(snp_cmd);
        present  = snp_valid && (snp_tag == line_tag) && (st != ST_I);
        clean    = (st == ST_S) || (st == ST_E);
        data_cmd = (cmd == CMD_RD) || (cmd == CMD_RDX);

        we         = present && (cmd != CMD_NONE);
        new_st     = (cmd == CMD_RD) ? ST_S : ST_I;
        shared_drv = present && (cmd == CMD_RD);
        flush      = present && (st == ST_M) && data_cmd;
        flush_c2c  = C2C_EN && present && clean && data_cmd && pick[MY_ID];
    end

endmodule

// File: rtl/mesi_proc_side.sv
module mesi_proc_side
    import mesi_pkg::*;
#(
    parameter int TAG_W       = 4,
    parameter bit USE_UPGRADE = 1'b1,
    parameter bit C2C_EN      = 1'b1
) (
    input  logic             pr_valid,
    input  logic             pr_write,
    input  logic [TAG_W-1:0] pr_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [1:0]       line_st,
    input  logic             bus_gnt,
    input  logic             bus_shared,
    input  logic             conflict,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic             pr_ready,
    output logic             pr_hit,
    output logic [1:0]       pr_state,
    output logic [1:0]       pr_src,
    output logic             we,
    output logic [1:0]       new_st
);
    line_st_e st;
    logic     valid;
    logic     needs_bus;

    always_comb begin
        st        = (pr_tag == line_tag) ? line_st_e'(line_st) : ST_I;
        valid     = (st != ST_I);
        needs_bus = !valid || (pr_write && (st == ST_S));

        if (!pr_valid || !needs_bus) bus_cmd = CMD_NONE;
        else if (!valid)             bus_cmd = pr_write ? CMD_RDX : CMD_RD;
        else                         bus_cmd = USE_UPGRADE ? CMD_UPG : CMD_RDX;

        bus_req  = pr_valid && needs_bus;
        pr_ready = pr_valid && !conflict && (!needs_bus || bus_gnt);
        pr_hit   = valid;
        pr_state = st;

        if (valid)                                   pr_src = SRC_OWN;
        else if (!pr_write && bus_shared && C2C_EN)  pr_src = SRC_PEER;
        else                                         pr_src = SRC_MEM;

        we = pr_ready;
        if (pr_write)   new_st = ST_M;
        else if (valid) new_st = st;
        else            new_st = bus_shared ? ST_S : ST_E;
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter int TAG_W       = 4,
    parameter int NCACHE      = 4,
    parameter int MY_ID       = 1,
    parameter bit USE_UPGRADE = 1'b1,
    parameter bit C2C_EN      = 1'b1,
    localparam int ADDR_W     = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pr_valid,
    input  logic              pr_write,
    input  logic [ADDR_W-1:0] pr_addr,
    output logic              pr_ready,
    output logic              pr_hit,
    output logic [1:0]        pr_state,
    output logic [1:0]        pr_src,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [NCACHE-1:0] snp_holders,
    output logic              snp_shared_drv,
    output logic              snp_flush,
    output logic              snp_flush_c2c
);
    logic [IDX_W-1:0] pr_idx, snp_idx;
    logic [TAG_W-1:0] pr_tag, snp_tag;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [1:0]       a_st, b_st;
    logic             p_we, s_we, conflict;
    logic [1:0]       p_st, s_st;

    assign pr_idx   = pr_addr[IDX_W-1:0];
    assign pr_tag   = pr_addr[ADDR_W-1:IDX_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
    assign bus_addr = pr_addr;
    assign conflict = s_we && (snp_idx == pr_idx);

    mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (pr_idx),
        .rd_a_tag (a_tag),
        .rd_a_st  (a_st),
        .rd_b_idx (snp_idx),
        .rd_b_tag (b_tag),
        .rd_b_st  (b_st),
        .pw_en    (p_we),
        .pw_idx   (pr_idx),
        .pw_tag   (pr_tag),
        .pw_st    (p_st),
        .sw_en    (s_we),
        .sw_idx   (snp_idx),
        .sw_st    (s_st)
    );

    mesi_proc_side #(.TAG_W(TAG_W), .USE_UPGRADE(USE_UPGRADE), .C2C_EN(C2C_EN)) u_proc (
        .pr_valid   (pr_valid),
        .pr_write   (pr_write),
        .pr_tag     (pr_tag),
        .line_tag   (a_tag),
        .line_st    (a_st),
        .bus_gnt    (bus_gnt),
        .bus_shared (bus_shared),
        .conflict   (conflict),
        .bus_req    (bus_req),
        .bus_cmd    (bus_cmd),
        .pr_ready   (pr_ready),
        .pr_hit     (pr_hit),
        .pr_state   (pr_state),
        .pr_src     (pr_src),
        .we         (p_we),
        .new_st     (p_st)
    );

    mesi_snoop_resp #(.TAG_W(TAG_W), .NCACHE(NCACHE), .MY_ID(MY_ID), .C2C_EN(C2C_EN)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_tag    (snp_tag),
        .holders    (snp_holders),
        .line_tag   (b_tag),
        .line_st    (b_st),
        .we         (s_we),
        .new_st     (s_st),
        .shared_drv (snp_shared_drv),
        .flush      (snp_flush),
        .flush_c2c  (snp_flush_c2c)
    );

    // R5: an ungranted request stays raised while the access is held
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req || !pr_valid || !$stable(pr_addr) || !$stable(pr_write)));

    // R3: a completion without grant never comes with a bus request
    assert_hit_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_ready && !bus_gnt) |-> !bus_req);

    // R8: dirty flush and clean supply never both drive
    assert_flush_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_flush && snp_flush_c2c));

    // R9: a flush on a snooped read comes from a holder that also drives shared
    assert_flush_shared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush && (snp_cmd == CMD_RD)) |-> snp_shared_drv);

    // R4: an upgrade is only requested for a shared line
    assert_upg_from_s_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_cmd == CMD_UPG)) |-> (pr_state == ST_S));

endmodule

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;
    localparam int IDX_W = 3, TAG_W = 4, NCACHE = 4, MY_ID = 1;
    localparam int ADDR_W = TAG_W + IDX_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pr_valid = 0, pr_write = 0;
    logic [ADDR_W-1:0] pr_addr = '0;
    logic pr_ready, pr_hit;
    logic [1:0] pr_state, pr_src;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_gnt = 0, bus_shared = 0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic [NCACHE-1:0] snp_holders = '0;
    logic snp_shared_drv, snp_flush, snp_flush_c2c;

    int checks = 0, errors = 0;
    int m_tag[8];
    int m_st[8];

    always #10 clk = ~clk;

    mesi_line_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .NCACHE(NCACHE), .MY_ID(MY_ID)) dut (
        .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_write(pr_write), .pr_addr(pr_addr),
        .pr_ready(pr_ready), .pr_hit(pr_hit), .pr_state(pr_state), .pr_src(pr_src),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
        .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_holders(snp_holders), .snp_shared_drv(snp_shared_drv), .snp_flush(snp_flush),
        .snp_flush_c2c(snp_flush_c2c)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    function automatic int lowest(input int h);
        for (int i = 0; i < NCACHE; i++) if (h[i]) return i;
        return -1;
    endfunction

    function automatic int cur_st(input int tag, input int idx);
        return (m_tag[idx] == tag) ? m_st[idx] : 0;
    endfunction

    task automatic proc_op(input bit wr, input int tag, input int idx, input bit sh, input int dly);
        int st, ecmd, esrc, nst;
        bit valid, needs;
        string rq;
        @(posedge clk); #1;
        st    = cur_st(tag, idx);
        valid = (st != 0);
        needs = !valid || (wr && st == 1);
        ecmd  = !valid ? (wr ? 2 : 1) : (needs ? 3 : 0);
        esrc  = valid ? 0 : ((!wr && sh) ? 2 : 1);
        nst   = wr ? 3 : (valid ? st : (sh ? 1 : 2));
        rq    = (!valid && !wr) ? "R2" : (needs ? "R4" : "R3");
        pr_addr = {tag[TAG_W-1:0], idx[IDX_W-1:0]};
        pr_valid = 1; pr_write = wr; bus_shared = sh;
        @(negedge clk);
        chk(bus_req == needs, "R5 bus_req raised", int'(bus_req), int'(needs));
        chk(pr_hit == valid, "R13 hit/miss", int'(pr_hit), int'(valid));
        if (needs) begin
            chk(bus_cmd == ecmd, rq, int'(bus_cmd), ecmd);
            chk(pr_ready == 0, "R5 stall before grant", int'(pr_ready), 0);
            for (int k = 0; k < dly; k++) begin
                @(posedge clk); #1;
                @(negedge clk);
                chk(bus_req == 1, "R5 request held", int'(bus_req), 1);
                chk(pr_state == st, "R5 no early update", int'(pr_state), st);
            end
            @(posedge clk); #1;
            bus_gnt = 1;
            @(negedge clk);
            chk(pr_ready == 1, "R5 ready in grant cycle", int'(pr_ready), 1);
        end else begin
            chk(pr_ready == 1, "R3 hit completes at once", int'(pr_ready), 1);
        end
        chk(pr_src == esrc, "R11 data source", int'(pr_src), esrc);
        @(posedge clk); #1;
        pr_valid = 0; bus_gnt = 0; bus_shared = 0;
        m_tag[idx] = tag; m_st[idx] = nst;
        @(negedge clk);
        chk(pr_state == nst, rq, int'(pr_state), nst);
    endtask

    task automatic snoop_op(input int cmd, input int tag, input int idx, input int others);
        int st, holders, nst, rtag;
        bit valid, esh, efl, ec2c;
        string rq;
        @(posedge clk); #1;
        st      = cur_st(tag, idx);
        valid   = (st != 0);
        holders = (others & ~(1 << MY_ID)) | (int'(valid) << MY_ID);
        esh     = valid && cmd == 1;
        efl     = (st == 3) && (cmd == 1 || cmd == 2);
        ec2c    = (st == 1 || st == 2) && (cmd == 1 || cmd == 2) && lowest(holders) == MY_ID;
        nst     = !valid ? m_st[idx] : (cmd == 1 ? 1 : 0);
        rq      = !valid ? "R10" : (st == 3 ? "R6" : "R7");
        rtag    = m_tag[idx];
        snp_addr = {tag[TAG_W-1:0], idx[IDX_W-1:0]};
        snp_cmd = cmd[1:0]; snp_holders = holders[NCACHE-1:0]; snp_valid = 1;
        pr_addr = {rtag[TAG_W-1:0], idx[IDX_W-1:0]};
        @(negedge clk);
        chk(snp_shared_drv == esh, valid ? "R9 shared drive" : "R10 no shared", int'(snp_shared_drv), int'(esh));
        chk(snp_flush == efl, valid ? "R6 dirty flush" : "R10 no flush", int'(snp_flush), int'(efl));
        chk(snp_flush_c2c == ec2c, valid ? "R8 clean supply" : "R10 no supply", int'(snp_flush_c2c), int'(ec2c));
        @(posedge clk); #1;
        snp_valid = 0;
        if (valid) m_st[idx] = nst;
        @(negedge clk);
        chk(pr_state == m_st[idx], rq, int'(pr_state), m_st[idx]);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin m_tag[i] = 0; m_st[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state on every index
        for (int i = 0; i < 8; i++) begin
            pr_addr = {4'd0, i[2:0]};
            @(negedge clk);
            chk(pr_state == 0, "R1 reset invalid", int'(pr_state), 0);
            chk(bus_req == 0, "R1 no request", int'(bus_req), 0);
        end
        // directed: fills both ways, hit, silent write, upgrade, tag replace
        proc_op(0, 1, 0, 0, 2);   // R2 -> E
        proc_op(0, 1, 1, 1, 0);   // R2 -> S, peer source
        proc_op(1, 1, 0, 0, 0);   // R3 E -> M silent
        proc_op(0, 1, 0, 0, 0);   // R3 read hit in M
        proc_op(1, 1, 1, 0, 1);   // R4 S -> M via upgrade
        proc_op(1, 2, 3, 0, 1);   // R4 miss write
        proc_op(0, 5, 0, 0, 0);   // R13 tag differs -> miss, replaced
        snoop_op(1, 2, 3, 4'b0000);   // R6 M read -> S
        snoop_op(2, 1, 1, 4'b0000);   // R6 M rdx -> I
        snoop_op(1, 5, 0, 4'b0001);   // R8 lower holder supplies, R7 -> S
        snoop_op(2, 7, 0, 4'b0000);   // R10 tag differs
        snoop_op(3, 5, 0, 4'b0000);   // R7 upgrade on S -> I
        // R12 conflict and R4 pending upgrade turning to read-for-ownership
        proc_op(0, 1, 2, 0, 0);       // E
        @(posedge clk); #1;
        pr_addr = {4'd1, 3'd2}; pr_valid = 1; pr_write = 1;
        snp_addr = {4'd1, 3'd2}; snp_cmd = 2'd1; snp_holders = 4'b0010; snp_valid = 1;
        @(negedge clk);
        chk(pr_ready == 0, "R12 local hit withheld", int'(pr_ready), 0);
        chk(snp_flush_c2c == 1, "R8 sole holder supplies", int'(snp_flush_c2c), 1);
        @(posedge clk); #1;
        snp_valid = 0;
        @(negedge clk);
        chk(bus_cmd == 3, "R12 re-evaluated as upgrade", int'(bus_cmd), 3);
        @(posedge clk); #1;
        snp_cmd = 2'd3; snp_holders = 4'b0011; snp_valid = 1;
        @(negedge clk);
        chk(snp_flush == 0 && snp_flush_c2c == 0, "R7 upgrade moves no data", int'(snp_flush), 0);
        @(posedge clk); #1;
        snp_valid = 0;
        @(negedge clk);
        chk(bus_cmd == 2, "R4 pending upgrade becomes rdx", int'(bus_cmd), 2);
        @(posedge clk); #1;
        bus_gnt = 1;
        @(negedge clk);
        chk(pr_src == 1, "R11 rdx from memory", int'(pr_src), 1);
        @(posedge clk); #1;
        bus_gnt = 0; pr_valid = 0;
        @(negedge clk);
        chk(pr_state == 3, "R4 ends modified", int'(pr_state), 3);
        m_tag[2] = 1; m_st[2] = 3;
        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int tag, idx, st;
            tag = $urandom_range(0, 1);
            idx = $urandom_range(0, 3);
            if ($urandom_range(0, 1) == 0) begin
                proc_op($urandom_range(0, 1), tag, idx, $urandom_range(0, 1), $urandom_range(0, 2));
            end else begin
                st = cur_st(tag, idx);
                snoop_op((st == 1) ? $urandom_range(1, 3) : $urandom_range(1, 2), tag, idx,
                         $urandom_range(0, 15));
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule